// File: doc/BRIEF.md
# Layered Normalized Min-Sum Decoder

This block decodes a short binary parity-check code by belief propagation. It uses normalized min-sum check updates on a serial, layered schedule. A stream of signed channel LLRs is loaded one variable per beat. The block then visits the checks one after another, and every check writes its refreshed posteriors back before the next check reads them. After each full sweep over the checks, it tests the syndrome of the hard decisions. Decoding ends on a zero syndrome or when the iteration budget runs out. The result leaves as a single output beat that carries the decision word, a converged flag and the number of iterations spent.

The connection pattern is a read-only table built from parameters: check `m` touches variables `(m + TAPS[k]) mod N`. The defaults give a cyclic 7-variable, 7-check code of row weight 3. Check messages and posteriors are kept in register memories that are rewritten in place. Channel values, check messages and posteriors each keep their own saturated width.

Top module: `nms_decoder`

## Requirements
- R1: Out of reset `s_ready` is 1 and `m_valid` is 0. In the load phase each beat accepted with `s_valid && s_ready` carries one 6-bit two's-complement LLR. Beat i initialises the posterior of variable i, for i = 0..N-1, and all check messages start at 0.
- R2: The new message from a check to one of its edges takes its sign from the XOR of the signs of the other edges' variable-to-check values, where a value below 0 counts as negative. Its magnitude is the least magnitude among those other edges, multiplied by 0.75 as `(x>>1)+(x>>2)`, which rounds toward zero, and then clipped to 127 so that it fits 8 bits signed.
- R3: Checks are processed in the order 0..M-1 in every iteration. A check first reads all its edges, then rewrites them, and its posterior writes are visible to the very next check.
- R4: The variable-to-check value is the posterior minus the stored message, saturated to [-512, 511]. The new posterior is that value plus the new message, saturated to the same 10-bit range.
- R5: Bit i of `m_data` is 1 exactly when the final posterior of variable i is negative.
- R6: After every iteration the syndrome of the hard decisions is evaluated. A zero syndrome stops decoding at once with `m_conv` = 1. If the syndrome is non-zero when decoding stops, `m_conv` is 0.
- R7: `max_iter` is sampled on the last load beat. Decoding stops after `max(max_iter, 1)` iterations at most, and `m_iters` reports how many iterations were run.
- R8: `m_valid` stays high with `m_data`, `m_conv` and `m_iters` stable until `m_ready` is seen. `s_ready` is low from the last load beat until that output beat is taken, and it is high again on the next cycle.
- R9: Check m connects to variables (m + TAPS[k]) mod N, k = 0..DC-1. The default TAPS are {0, 1, 3} with N = M = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| max_iter | input | IW | Iteration budget, sampled on the last load beat |
| s_valid | input | 1 | LLR beat valid |
| s_ready | output | 1 | Block can take an LLR beat |
| s_data | input | LW | Signed channel LLR |
| m_valid | output | 1 | Decision beat valid |
| m_ready | input | 1 | Sink takes the decision beat |
| m_data | output | N | Hard decisions, bit i is variable i |
| m_conv | output | 1 | Syndrome was zero when decoding stopped |
| m_iters | output | IW | Iterations run |

## Verification
The assertions assume a single active-low reset at start and `m_ready` inputs that change only away from the clock edge. Under those assumptions they check that the two stream sides are never open together, that an offered result is held steady under backpressure, and that a result flagged as converged really satisfies every check. They also assume the sink eventually takes the result. The stimulus keeps every LLR inside the 6-bit range and every budget inside 0..15, and it holds `max_iter` steady while loading. Backpressure is bounded to a few cycles, so every decode finishes. Random noisy words and directed extremes (strong, single-error, all-negative, zero budget) drive the posterior and message saturation points.

// File: rtl/nms_pkg.sv
package nms_pkg;
    typedef enum logic [2:0] {
        ST_LOAD  = 3'd0,
        ST_PASS1 = 3'd1,
        ST_PASS2 = 3'd2,
        ST_SYND  = 3'd3,
        ST_DONE  = 3'd4
    } state_e;
endpackage

// File: rtl/nms_hrom.sv
// Read-only connection table: check m, slot k -> variable (m + TAPS[k]) mod N (R9).
module nms_hrom #(
    parameter int N   = 7,
    parameter int M   = 7,
    parameter int DC  = 3,
    parameter logic [DC-1:0][7:0] TAPS = {8'd3, 8'd1, 8'd0},
    localparam int CIW = $clog2(N)
) (
    output logic [M*DC-1:0][CIW-1:0] cols
);
    for (genvar m = 0; m < M; m++) begin : g_row
        for (genvar k = 0; k < DC; k++) begin : g_slot
            assign cols[m*DC+k] = CIW'((m + int'(TAPS[k])) % N);
        end
    end
endmodule

// File: rtl/nms_satadd.sv
// W-bit signed add or subtract with saturation (R4).
module nms_satadd #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W:0] ext_a, ext_b, sum;

    always_comb begin
        ext_a = {a[W-1], a};
        ext_b = {b[W-1], b};
        sum   = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        if (sum[W] != sum[W-1]) begin
            y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            y = sum[W-1:0];
        end
    end
endmodule

// File: rtl/nms_cnode.sv
// Check-node arithmetic: one-pass min1/min2/index/parity tracking and
// per-edge normalized message output (R2).
module nms_cnode #(
    parameter int VW = 10,
    parameter int CW = 8,
    parameter int DC = 3,
    localparam int SW = $clog2(DC)
) (
    input  logic [VW-1:0] q_in,
    input  logic          first,
    input  logic [SW-1:0] slot,
    input  logic [VW-1:0] min1_q,
    input  logic [VW-1:0] min2_q,
    input  logic [SW-1:0] idx_q,
    input  logic          par_q,
    output logic [VW-1:0] min1_d,
    output logic [VW-1:0] min2_d,
    output logic [SW-1:0] idx_d,
    output logic          par_d,
    input  logic [VW-1:0] q_old,
    output logic [CW-1:0] msg_out
);
    localparam logic [VW-1:0] MAXM = VW'((2 ** (CW - 1)) - 1);

    logic [VW-1:0] mag;
    logic [VW-1:0] sel, scaled;
    logic [CW-2:0] clipped;
    logic          sgn;

    always_comb begin
        mag = q_in[VW-1] ? (~q_in + VW'(1)) : q_in;
        if (first) begin
            min1_d = mag;
            min2_d = '1;
            idx_d  = slot;
            par_d  = q_in[VW-1];
        end else begin
            min1_d = min1_q;
            min2_d = min2_q;
            idx_d  = idx_q;
            par_d  = par_q ^ q_in[VW-1];
            if (mag < min1_q) begin
                min2_d = min1_q;
                min1_d = mag;
                idx_d  = slot;
            end else if (mag < min2_q) begin
                min2_d = mag;
            end
        end
    end

    always_comb begin
        sel     = (slot == idx_q) ? min2_q : min1_q;
        scaled  = (sel >> 1) + (sel >> 2);
        clipped = (scaled > MAXM) ? MAXM[CW-2:0] : scaled[CW-2:0];
        sgn     = par_q ^ q_old[VW-1];
        msg_out = sgn ? (~{1'b0, clipped} + CW'(1)) : {1'b0, clipped};
    end
endmodule

// File: rtl/nms_syndrome.sv
// Parity of the hard decisions on every check; flags an all-zero syndrome (R6).
module nms_syndrome #(
    parameter int N  = 7,
    parameter int M  = 7,
    parameter int DC = 3,
    localparam int CIW = $clog2(N)
) (
    input  logic [N-1:0]              hard,
    input  logic [M*DC-1:0][CIW-1:0]  cols,
    output logic                      zero
);
    logic [M-1:0] synd;

    always_comb begin
        for (int m = 0; m < M; m++) begin
            synd[m] = 1'b0;
            for (int k = 0; k < DC; k++) begin
                synd[m] = synd[m] ^ hard[cols[m*DC+k]];
            end
        end
        zero = (synd == '0);
    end
endmodule

// File: rtl/nms_decoder.sv
// Serial-schedule normalized min-sum decoder, top level.
module nms_decoder #(
    parameter int N  = 7,
    parameter int M  = 7,
    parameter int DC = 3,
    parameter logic [DC-1:0][7:0] TAPS = {8'd3, 8'd1, 8'd0},
    parameter int LW = 6,
    parameter int CW = 8,
    parameter int VW = 10,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] max_iter,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [LW-1:0] s_data,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [N-1:0]  m_data,
    output logic          m_conv,
    output logic [IW-1:0] m_iters
);
    import nms_pkg::*;

    localparam int CIW   = $clog2(N);
    localparam int RW    = $clog2(M);
    localparam int SW    = $clog2(DC);
    localparam int E     = M * DC;
    localparam int EW    = $clog2(E);
    localparam int CNT_W = $clog2(N + DC);

    typedef struct packed {
        state_e                  st;
        logic [CNT_W-1:0]        cnt;
        logic [RW-1:0]           row;
        logic [IW-1:0]           iter;
        logic [IW-1:0]           maxit;
        logic [VW-1:0]           min1;
        logic [VW-1:0]           min2;
        logic [SW-1:0]           idx;
        logic                    par;
        logic                    conv;
        logic [DC-1:0][VW-1:0]   qbuf;
        logic [N-1:0][VW-1:0]    post;
        logic [E-1:0][CW-1:0]    msg;
    } state_t;

    state_t s_q, s_d;

    logic [E-1:0][CIW-1:0] cols;
    logic [EW-1:0]         edge_sel;
    logic [SW-1:0]         slot;
    logic [CIW-1:0]        col;
    logic [VW-1:0]         q_new, post_new;
    logic [CW-1:0]         msg_new;
    logic [VW-1:0]         min1_n, min2_n;
    logic [SW-1:0]         idx_n;
    logic                  par_n;
    logic [N-1:0]          hard;
    logic                  synd_zero;
    logic [IW-1:0]         iter_inc;

    nms_hrom #(.N(N), .M(M), .DC(DC), .TAPS(TAPS)) i_hrom (.cols(cols));

    assign slot     = SW'(s_q.cnt);
    assign edge_sel = EW'(int'(s_q.row) * DC + int'(s_q.cnt));
    assign col      = cols[edge_sel];

    nms_satadd #(.W(VW)) i_v2c (
        .a   (s_q.post[col]),
        .b   ({{(VW-CW){s_q.msg[edge_sel][CW-1]}}, s_q.msg[edge_sel]}),
        .sub (1'b1),
        .y   (q_new)
    );

    nms_cnode #(.VW(VW), .CW(CW), .DC(DC)) i_cnode (
        .q_in    (q_new),
        .first   (s_q.cnt == '0),
        .slot    (slot),
        .min1_q  (s_q.min1),
        .min2_q  (s_q.min2),
        .idx_q   (s_q.idx),
        .par_q   (s_q.par),
        .min1_d  (min1_n),
        .min2_d  (min2_n),
        .idx_d   (idx_n),
        .par_d   (par_n),
        .q_old   (s_q.qbuf[slot]),
        .msg_out (msg_new)
    );

    nms_satadd #(.W(VW)) i_post (
        .a   (s_q.qbuf[slot]),
        .b   ({{(VW-CW){msg_new[CW-1]}}, msg_new}),
        .sub (1'b0),
        .y   (post_new)
    );

    always_comb begin
        for (int i = 0; i < N; i++) hard[i] = s_q.post[i][VW-1];
    end

    nms_syndrome #(.N(N), .M(M), .DC(DC)) i_synd (
        .hard (hard),
        .cols (cols),
        .zero (synd_zero)
    );

    assign iter_inc = s_q.iter + IW'(1);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_LOAD: begin
                if (s_valid) begin
                    s_d.post[CIW'(s_q.cnt)] = {{(VW-LW){s_data[LW-1]}}, s_data};
                    if (s_q.cnt == CNT_W'(N - 1)) begin
                        s_d.cnt   = '0;
                        s_d.row   = '0;
                        s_d.iter  = '0;
                        s_d.maxit = max_iter;
                        s_d.msg   = '0;
                        s_d.st    = ST_PASS1;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_PASS1: begin
                s_d.qbuf[slot] = q_new;
                s_d.min1       = min1_n;
                s_d.min2       = min2_n;
                s_d.idx        = idx_n;
                s_d.par        = par_n;
                if (s_q.cnt == CNT_W'(DC - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_PASS2;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_PASS2: begin
                s_d.post[col]      = post_new;
                s_d.msg[edge_sel]  = msg_new;
                if (s_q.cnt == CNT_W'(DC - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.row == RW'(M - 1)) begin
                        s_d.st = ST_SYND;
                    end else begin
                        s_d.row = s_q.row + RW'(1);
                        s_d.st  = ST_PASS1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_SYND: begin
                s_d.iter = iter_inc;
                s_d.row  = '0;
                if (synd_zero || (iter_inc >= s_q.maxit)) begin
                    s_d.conv = synd_zero;
                    s_d.st   = ST_DONE;
                end else begin
                    s_d.st = ST_PASS1;
                end
            end
            ST_DONE: begin
                if (m_ready) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_LOAD;
                end
            end
            default: s_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign s_ready = (s_q.st == ST_LOAD);
    assign m_valid = (s_q.st == ST_DONE);
    assign m_data  = hard;
    assign m_conv  = s_q.conv;
    assign m_iters = s_q.iter;
endmodule

// File: rtl/nms_decoder_chk.sv
// Port-level properties of the decoder, bound to every instance.
module nms_decoder_chk #(
    parameter int N  = 7,
    parameter int M  = 7,
    parameter int DC = 3,
    parameter logic [DC-1:0][7:0] TAPS = {8'd3, 8'd1, 8'd0},
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          m_valid,
    input logic          m_ready,
    input logic [N-1:0]  m_data,
    input logic          m_conv,
    input logic [IW-1:0] m_iters
);
    function automatic logic parity_ok(input logic [N-1:0] w);
        logic bad;
        bad = 1'b0;
        for (int m = 0; m < M; m++) begin
            logic p;
            p = 1'b0;
            for (int k = 0; k < DC; k++) p = p ^ w[(m + int'(TAPS[k])) % N];
            bad = bad | p;
        end
        return !bad;
    endfunction

    // R8: input and output sides never open in the same cycle
    p_sides_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    // R8: an offered result is held until taken
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_conv) && $stable(m_iters)));

    // R6: a converged result satisfies every check
    p_conv_syndrome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_conv) |-> parity_ok(m_data));

    // R7: at least one iteration always runs
    p_iters_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_iters != '0));
endmodule

bind nms_decoder nms_decoder_chk #(.N(N), .M(M), .DC(DC), .TAPS(TAPS), .IW(IW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_conv  (m_conv),
    .m_iters (m_iters)
);

// File: tb/test_nms_decoder.sv
module test_nms_decoder;
    localparam int N  = 7;
    localparam int M  = 7;
    localparam int DC = 3;
    localparam int LW = 6;
    localparam int IW = 4;
    localparam int TAP_B [DC] = '{0, 1, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] max_iter = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [LW-1:0] s_data = '0;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic [N-1:0]  m_data;
    logic          m_conv;
    logic [IW-1:0] m_iters;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nms_decoder i_nms_decoder (
        .clk(clk), .rst_n(rst_n), .max_iter(max_iter),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_conv(m_conv), .m_iters(m_iters)
    );

    // reference model state
    int          r_llr  [N];
    int          r_post [N];
    int          r_msg  [M][DC];
    logic [N-1:0] e_dec;
    bit          e_conv;
    int          e_its;

    function automatic int clip(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int col_of(input int m, input int k);
        return (m + TAP_B[k]) % N;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R6 R7: reference decoder written from the requirements
    task automatic ref_run(input int mx);
        int q [DC];
        for (int i = 0; i < N; i++) r_post[i] = r_llr[i];
        for (int m = 0; m < M; m++) for (int k = 0; k < DC; k++) r_msg[m][k] = 0;
        e_its = 0;
        e_conv = 0;
        for (int it = 0; it < 64; it++) begin
            bit bad;
            for (int m = 0; m < M; m++) begin
                for (int k = 0; k < DC; k++)
                    q[k] = clip(r_post[col_of(m, k)] - r_msg[m][k], -512, 511);
                for (int k = 0; k < DC; k++) begin
                    int mn, sc, nm;
                    bit sg;
                    mn = 1 << 20;
                    sg = 0;
                    for (int j = 0; j < DC; j++) begin
                        if (j != k) begin
                            int a;
                            a = (q[j] < 0) ? -q[j] : q[j];
                            if (a < mn) mn = a;
                            if (q[j] < 0) sg = ~sg;
                        end
                    end
                    sc = (mn >> 1) + (mn >> 2);
                    if (sc > 127) sc = 127;
                    nm = sg ? -sc : sc;
                    r_msg[m][k] = nm;
                    r_post[col_of(m, k)] = clip(q[k] + nm, -512, 511);
                end
            end
            e_its++;
            for (int i = 0; i < N; i++) e_dec[i] = (r_post[i] < 0);
            bad = 0;
            for (int m = 0; m < M; m++) begin
                bit p;
                p = 0;
                for (int k = 0; k < DC; k++) p = p ^ e_dec[col_of(m, k)];
                bad = bad | p;
            end
            if (!bad) begin
                e_conv = 1;
                break;
            end
            if (e_its >= mx) break;
        end
    endtask

    task automatic run_case(input int mx, input int stall);
        logic [N-1:0] held;
        int waited;
        max_iter = IW'(mx);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            while (!s_ready) @(negedge clk);
            s_valid = 1'b1;
            s_data  = LW'(r_llr[i]);
        end
        @(negedge clk);
        s_valid = 1'b0;
        check("R8 s_ready low while decoding", int'(s_ready), 0);
        ref_run(mx);
        waited = 0;
        while (!m_valid && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R2/R3/R4/R5 decisions", int'(m_data), int'(e_dec));
        check("R6 converged flag", int'(m_conv), int'(e_conv));
        check("R7 iteration count", int'(m_iters), e_its);
        held = m_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R8 m_valid held", int'(m_valid), 1);
            check("R8 m_data held", int'(m_data), int'(held));
        end
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        check("R8 s_ready after take", int'(s_ready), 1);
        check("R1 m_valid low after take", int'(m_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 s_ready in reset", int'(s_ready), 1);
        check("R1 m_valid in reset", int'(m_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 s_ready after reset", int'(s_ready), 1);

        // directed: strong all-zero word converges in one sweep (R6)
        for (int i = 0; i < N; i++) r_llr[i] = 31;
        run_case(8, 0);
        check("R6 strong word one iteration", int'(m_iters), 1);

        // directed: one weak wrong bit is corrected (R2, R9)
        for (int i = 0; i < N; i++) r_llr[i] = 20;
        r_llr[2] = -5;
        run_case(8, 2);

        // directed: all most-negative, budget limit and saturation (R4, R7)
        for (int i = 0; i < N; i++) r_llr[i] = -32;
        run_case(5, 1);

        // directed: zero budget runs one iteration (R7)
        for (int i = 0; i < N; i++) r_llr[i] = (i % 2 == 0) ? -32 : 31;
        run_case(0, 0);
        check("R7 zero budget", int'(m_iters), 1);

        // directed: full budget with mixed extremes (R4, R7)
        for (int i = 0; i < N; i++) r_llr[i] = (i < 3) ? -32 : 31;
        run_case(15, 3);

        // constrained random: noisy all-zero word and arbitrary words
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < N; i++) begin
                if (t % 2 == 0) r_llr[i] = clip(int'($urandom_range(0, 44)) - 14, -32, 31);
                else            r_llr[i] = int'($urandom_range(0, 63)) - 32;
            end
            run_case(int'($urandom_range(0, 12)), int'($urandom_range(0, 3)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule